// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block is the host-side consumer of a small ring of receive descriptors. The ring lives in a local descriptor memory, two 32-bit words per entry: a status word at even word addresses and a control word at odd ones. A receive engine, modelled here by an external write port, fills in status words and clears their ownership flag once a frame has landed in the matching buffer. On each poll request the block looks at the descriptor under its ring pointer. If the receive engine still owns that descriptor, the poll ends at once. If the host owns it, the block classifies the frame and reports either a deliverable length or a reason for dropping it.

After a poll that found a host-owned descriptor, the block hands descriptors back to the engine. Starting at the current entry, it walks forward around the ring. It sets the ownership flag on each descriptor for as long as it keeps finding host-owned entries, up to one full lap. It then pulses a poll-demand strobe so that a stalled engine starts again. At reset the block first runs an initialisation pass. This pass gives every descriptor to the engine, writes the buffer size into every control word and sets the ring pointer to entry zero.

Top module: `rx_ring_consumer`

## Requirements
- R1: After reset the initialisation pass writes 0x8000_0000 to every status word (bit 31 is ownership; 1 means the engine owns it) and writes 1536 into bits 10:0 of every control word. Word address = 2*index + select, with select 0 for status and 1 for control.
- R2: When the descriptor under the ring pointer has bit 31 set, the poll produces one result with class 1 (empty) and no frame-valid. The block rewrites nothing, moves no pointer and gives no poll-demand strobe.
- R3: A host-owned status word with bit 7 clear and with both bit 11 (first) and bit 10 (last) set is delivered. The block gives class 0, frame-valid, a length equal to bits 27:16 minus 4, and buffer index = the descriptor's ring index.
- R4: A host-owned status word with bit 7 (error summary) set is dropped, and the class is chosen in this priority order: bit 6 (runt) or bit 5 (long) gives 2; otherwise bit 2 (receive error) gives 3; otherwise bit 3 (CRC) gives 4; otherwise 5.
- R5: A host-owned status word with bit 7 clear but without both bit 11 and bit 10 set spans several buffers and is dropped with class 6.
- R6: After a poll that found a host-owned descriptor, the block writes 0x8000_0000 into the status word of each consecutive host-owned descriptor from the current one onward. It advances the ring pointer once per descriptor, and the pointer wraps from the last index to 0.
- R7: Reclaiming stops after at most DEPTH descriptors in one poll, even if every one of them reads host-owned.
- R8: Each poll that found a host-owned descriptor gives exactly one poll-demand pulse, and that pulse comes after the poll's result.
- R9: Each accepted poll gives exactly one result pulse. A poll request that arrives while a poll is still in progress is ignored.
- R10: The engine port returns the word at eng_addr on eng_rdata one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the initialisation pass |
| poll_req | input | 1 | Request one poll of the ring; taken only while idle |
| eng_we | input | 1 | Engine write strobe into the descriptor memory |
| eng_addr | input | 3 | Engine word address (2*index + select) |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data, one cycle after eng_addr |
| result_valid | output | 1 | One-cycle pulse, one per poll, qualifying err_class and buf_idx |
| frm_valid | output | 1 | One-cycle pulse when the polled frame is deliverable |
| frm_len | output | 12 | Frame length with the CRC removed |
| err_class | output | 3 | 0 ok, 1 empty, 2 length, 3 receive error, 4 CRC, 5 other error, 6 multi-buffer |
| buf_idx | output | 2 | Ring index of the polled descriptor |
| poll_demand | output | 1 | One-cycle restart strobe to the receive engine after reclaiming |

## Verification
The checker relies on two things about the inputs. The engine port writes only while the block is idle, and never in the cycle a poll request is taken, so the block's own status rewrites are never overwritten mid-poll. The length field of any status word the block reports is at least 4. The stimulus respects both: it loads descriptors before raising the poll request and waits well past the longest reclaim walk before touching memory again. The one deliberate exception is a second poll request pulsed during a reclaim walk, which must have no effect.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DESC_W    = 32;
  localparam int LEN_W     = 12;
  localparam int CRC_BYTES = 4;

  localparam int OWN_BIT   = 31;
  localparam int LEN_HI    = 27;
  localparam int LEN_LO    = 16;
  localparam int FIRST_BIT = 11;
  localparam int LAST_BIT  = 10;
  localparam int ESUM_BIT  = 7;
  localparam int RUNT_BIT  = 6;
  localparam int LONG_BIT  = 5;
  localparam int CRC_BIT   = 3;
  localparam int RXERR_BIT = 2;

  typedef enum logic [2:0] {
    CLS_OK    = 3'd0,
    CLS_EMPTY = 3'd1,
    CLS_LEN   = 3'd2,
    CLS_FRAME = 3'd3,
    CLS_CRC   = 3'd4,
    CLS_OTHER = 3'd5,
    CLS_SPLIT = 3'd6
  } rx_cls_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_EVAL,
    ST_WAIT,
    ST_CHECK
  } ctl_st_e;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  // one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end
endmodule

// File: rtl/rxr_status_dec.sv
module rxr_status_dec
  import rxr_pkg::*;
(
  input  logic [DESC_W-1:0] status,
  output rx_cls_e           cls,
  output logic [LEN_W-1:0]  len
);
  logic unused_bits;
  assign unused_bits = ^{status[30:28], status[15:12], status[9:8],
                         status[4], status[1:0]};

  always_comb begin
    len = status[LEN_HI:LEN_LO] - LEN_W'(CRC_BYTES);
    if (status[OWN_BIT]) begin
      cls = CLS_EMPTY;
    end else if (status[ESUM_BIT]) begin
      if (status[RUNT_BIT] || status[LONG_BIT]) cls = CLS_LEN;
      else if (status[RXERR_BIT])               cls = CLS_FRAME;
      else if (status[CRC_BIT])                 cls = CLS_CRC;
      else                                      cls = CLS_OTHER;
    end else if (!(status[FIRST_BIT] && status[LAST_BIT])) begin
      cls = CLS_SPLIT;
    end else begin
      cls = CLS_OK;
    end
  end
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int BUF_BYTES = 1536,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW = IW + 1,
  localparam int SW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_req,
  input  logic              rd_own,
  input  rx_cls_e           cls,
  input  logic [LEN_W-1:0]  len,
  output logic [AW-1:0]     rd_addr,
  output logic              init_we,
  output logic              recl_we,
  output logic [AW-1:0]     wr_addr,
  output logic [DESC_W-1:0] wr_data,
  output logic              result_valid,
  output logic              frm_valid,
  output logic [LEN_W-1:0]  frm_len,
  output logic [2:0]        err_class,
  output logic [IW-1:0]     buf_idx,
  output logic              poll_demand
);
  localparam logic [DESC_W-1:0] OWN_WORD  = DESC_W'(1) << OWN_BIT;
  localparam logic [DESC_W-1:0] CTRL_WORD = DESC_W'(BUF_BYTES);

  ctl_st_e       state;
  logic [IW-1:0] ptr;
  logic [IW-1:0] ptr_nxt;
  logic [SW-1:0] steps;
  logic [AW-1:0] init_cnt;

  assign ptr_nxt = (ptr == IW'(DEPTH - 1)) ? '0 : ptr + IW'(1);
  assign rd_addr = {ptr, 1'b0};

  always_comb begin
    init_we = (state == ST_INIT);
    recl_we = ((state == ST_EVAL) && (cls != CLS_EMPTY)) ||
              ((state == ST_CHECK) && !rd_own && (steps != SW'(DEPTH)));
    if (state == ST_INIT) begin
      wr_addr = init_cnt;
      wr_data = init_cnt[0] ? CTRL_WORD : OWN_WORD;
    end else begin
      wr_addr = {ptr, 1'b0};
      wr_data = OWN_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_INIT;
      init_cnt     <= '0;
      ptr          <= '0;
      steps        <= '0;
      result_valid <= 1'b0;
      frm_valid    <= 1'b0;
      frm_len      <= '0;
      err_class    <= '0;
      buf_idx      <= '0;
      poll_demand  <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      frm_valid    <= 1'b0;
      poll_demand  <= 1'b0;
      case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + AW'(1);
          if (init_cnt == AW'(2 * DEPTH - 1)) begin
            ptr   <= '0;
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (poll_req) state <= ST_EVAL;
        end
        ST_EVAL: begin
          result_valid <= 1'b1;
          err_class    <= cls;
          frm_len      <= len;
          buf_idx      <= ptr;
          frm_valid    <= (cls == CLS_OK);
          if (cls == CLS_EMPTY) begin
            state <= ST_IDLE;
          end else begin
            ptr   <= ptr_nxt;
            steps <= SW'(1);
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          // registered read of the new pointer lands here
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (recl_we) begin
            ptr   <= ptr_nxt;
            steps <= steps + SW'(1);
            state <= ST_WAIT;
          end else begin
            poll_demand <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_consumer.sv
module rx_ring_consumer
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int BUF_BYTES = 1536,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int AW = IW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_req,
  input  logic              eng_we,
  input  logic [AW-1:0]     eng_addr,
  input  logic [DESC_W-1:0] eng_wdata,
  output logic [DESC_W-1:0] eng_rdata,
  output logic              result_valid,
  output logic              frm_valid,
  output logic [LEN_W-1:0]  frm_len,
  output logic [2:0]        err_class,
  output logic [IW-1:0]     buf_idx,
  output logic              poll_demand
);
  logic [AW-1:0]     rd_addr;
  logic [DESC_W-1:0] rd_status;
  logic              init_we;
  logic              recl_we;
  logic              blk_we;
  logic [AW-1:0]     wr_addr;
  logic [DESC_W-1:0] wr_data;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DESC_W-1:0] mem_wdata;
  rx_cls_e           cls;
  logic [LEN_W-1:0]  len;

  // block writes win over the engine port
  assign blk_we    = init_we | recl_we;
  assign mem_we    = blk_we | eng_we;
  assign mem_waddr = blk_we ? wr_addr : eng_addr;
  assign mem_wdata = blk_we ? wr_data : eng_wdata;

  rxr_desc_mem #(.AW(AW), .DW(DESC_W)) u_mem (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .a_addr (rd_addr),
    .a_data (rd_status),
    .b_addr (eng_addr),
    .b_data (eng_rdata)
  );

  rxr_status_dec u_dec (
    .status (rd_status),
    .cls    (cls),
    .len    (len)
  );

  rxr_ring_ctrl #(.DEPTH(DEPTH), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .poll_req     (poll_req),
    .rd_own       (rd_status[OWN_BIT]),
    .cls          (cls),
    .len          (len),
    .rd_addr      (rd_addr),
    .init_we      (init_we),
    .recl_we      (recl_we),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .result_valid (result_valid),
    .frm_valid    (frm_valid),
    .frm_len      (frm_len),
    .err_class    (err_class),
    .buf_idx      (buf_idx),
    .poll_demand  (poll_demand)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
  import rxr_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1) + 1
) (
  input logic       clk,
  input logic       rst,
  input logic       result_valid,
  input logic       frm_valid,
  input logic [2:0] err_class,
  input logic       poll_demand,
  input logic       recl_we
);
  logic          outstanding;
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      wcnt        <= '0;
    end else begin
      if (result_valid && (err_class != 3'(CLS_EMPTY))) outstanding <= 1'b1;
      else if (poll_demand)                             outstanding <= 1'b0;
      if (poll_demand)  wcnt <= '0;
      else if (recl_we) wcnt <= wcnt + CW'(1);
    end
  end

  a_r3_frame_means_ok: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> (result_valid && (err_class == 3'(CLS_OK))));

  a_r2_empty_no_write: assert property (@(posedge clk) disable iff (rst)
    (result_valid && (err_class == 3'(CLS_EMPTY))) |-> !$past(recl_we));

  a_r7_reclaim_cap: assert property (@(posedge clk) disable iff (rst)
    recl_we |-> (wcnt < CW'(DEPTH)));

  a_r8_demand_after_result: assert property (@(posedge clk) disable iff (rst)
    poll_demand |-> outstanding);

  a_r8_single_demand: assert property (@(posedge clk) disable iff (rst)
    poll_demand |=> !poll_demand);

  a_r9_one_result_per_poll: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !outstanding);
endmodule

bind rx_ring_consumer rxr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .result_valid (result_valid),
  .frm_valid    (frm_valid),
  .err_class    (err_class),
  .poll_demand  (poll_demand),
  .recl_we      (recl_we)
);

// File: tb/test_rx_ring_consumer.sv
`timescale 1ns/1ps
module test_rx_ring_consumer;
  localparam int DEPTH = 4;
  localparam int IW    = 2;
  localparam int AW    = 3;
  localparam logic [31:0] OWNW = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        poll_req;
  logic        eng_we;
  logic [AW-1:0] eng_addr;
  logic [31:0] eng_wdata;
  logic [31:0] eng_rdata;
  logic        result_valid;
  logic        frm_valid;
  logic [11:0] frm_len;
  logic [2:0]  err_class;
  logic [IW-1:0] buf_idx;
  logic        poll_demand;

  always #2 clk = ~clk;

  rx_ring_consumer #(.DEPTH(DEPTH), .BUF_BYTES(1536)) i_rx_ring_consumer (
    .clk(clk), .rst(rst), .poll_req(poll_req), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .result_valid(result_valid), .frm_valid(frm_valid), .frm_len(frm_len),
    .err_class(err_class), .buf_idx(buf_idx), .poll_demand(poll_demand)
  );

  typedef struct {
    int    cls;
    int    idx;
    int    len;
    string req;
  } exp_t;

  exp_t        exp_q[$];
  int          dem_q[$];
  logic [31:0] mstat [DEPTH];
  int          mptr;
  int          checks = 0;
  int          errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int model_cls(input logic [31:0] s);
    if (s[31]) return 1;
    if (s[7]) begin
      if (s[6] || s[5]) return 2;
      if (s[2]) return 3;
      if (s[3]) return 4;
      return 5;
    end
    if (!(s[11] && s[10])) return 6;
    return 0;
  endfunction

  function automatic logic [31:0] mk(input int lenf, input bit first,
                                     input bit last, input logic [7:0] err);
    return (32'(lenf) << 16) | (32'(first) << 11) | (32'(last) << 10) | 32'(err);
  endfunction

  // monitor: compares results and strobes against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (result_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(int'(err_class) == e.cls, e.req, "class", err_class, e.cls);
          check(int'(buf_idx) == e.idx, e.req, "buffer index", buf_idx, e.idx);
          check(frm_valid == (e.cls == 0), e.req, "frame valid", frm_valid, e.cls == 0);
          if (e.cls == 0)
            check(int'(frm_len) == e.len, "R3", "length", frm_len, e.len);
        end
      end
      if (poll_demand) begin
        if (dem_q.size() == 0) check(1'b0, "R8", "unexpected poll demand", 1, 0);
        else begin
          void'(dem_q.pop_front());
          check(1'b1, "R8", "poll demand", 1, 1);
        end
      end
    end
  end

  task automatic eng_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    eng_we = 1'b1; eng_addr = AW'(idx * 2); eng_wdata = d;
    @(negedge clk);
    eng_we = 1'b0;
    mstat[idx] = d;
  endtask

  task automatic eng_read(input int a, output logic [31:0] d);
    @(negedge clk);
    eng_addr = AW'(a);
    @(negedge clk);
    d = eng_rdata;
  endtask

  task automatic verify_ring(input string req);
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      eng_read(i * 2, d);
      check(d == mstat[i], req, $sformatf("status word %0d", i), d, mstat[i]);
    end
  endtask

  task automatic do_poll(input bit extra);
    exp_t e;
    e.cls = model_cls(mstat[mptr]);
    e.idx = mptr;
    e.len = int'(mstat[mptr][27:16]) - 4;
    case (e.cls)
      0: e.req = "R3";
      1: e.req = "R2";
      6: e.req = "R5";
      default: e.req = "R4";
    endcase
    exp_q.push_back(e);
    if (e.cls != 1) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (mstat[mptr][31]) break;
        mstat[mptr] = OWNW;
        mptr = (mptr + 1) % DEPTH;
      end
      dem_q.push_back(1);
    end
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    if (extra) begin
      @(negedge clk); poll_req = 1'b1;   // lands while the poll is busy
      @(negedge clk); poll_req = 1'b0;
    end
    repeat (24) @(negedge clk);
    check(exp_q.size() == 0, "R9", "result count", exp_q.size(), 0);
    check(dem_q.size() == 0, "R8", "demand count", dem_q.size(), 0);
    verify_ring("R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; poll_req = 1'b0; eng_we = 1'b0; eng_addr = '0; eng_wdata = '0;
    mptr = 0;
    for (int i = 0; i < DEPTH; i++) mstat[i] = OWNW;
    repeat (3) @(negedge clk);
    check(result_valid == 1'b0, "R9", "reset result", result_valid, 0);
    check(frm_valid == 1'b0, "R3", "reset frame valid", frm_valid, 0);
    check(poll_demand == 1'b0, "R8", "reset demand", poll_demand, 0);
    rst = 1'b0;
    repeat (2 * DEPTH + 4) @(negedge clk);

    // R1 / R10: initialisation contents through the one-cycle read port
    for (int i = 0; i < DEPTH; i++) begin
      eng_read(i * 2, d);
      check(d == OWNW, "R1", "init status", d, OWNW);
      eng_read(i * 2 + 1, d);
      check(d[10:0] == 11'd1536, "R10", "init control", d[10:0], 1536);
    end

    // R2: engine still owns descriptor 0
    do_poll(1'b0);

    // R3: good frame in descriptor 0
    eng_write(0, mk(68, 1, 1, 8'h00));
    do_poll(1'b0);

    // R4 runt in 1, good frame in 2 reclaimed too; R9 extra request ignored
    eng_write(1, mk(40, 1, 1, 8'hC0));
    eng_write(2, mk(100, 1, 1, 8'h00));
    do_poll(1'b1);

    // R5: multi-buffer frame in 3, pointer wraps to 0
    eng_write(3, mk(1000, 1, 0, 8'h00));
    do_poll(1'b0);

    // R7: whole ring host-owned, walk capped at one lap
    eng_write(0, mk(80, 1, 1, 8'h88));
    eng_write(1, mk(80, 1, 1, 8'h00));
    eng_write(2, mk(80, 0, 1, 8'h00));
    eng_write(3, mk(80, 1, 1, 8'h80));
    do_poll(1'b0);
    do_poll(1'b0);  // pointer back at 0, engine-owned

    // R4 priorities, one descriptor per poll
    eng_write(0, mk(70, 1, 1, 8'h8C));
    do_poll(1'b0);
    eng_write(1, mk(70, 1, 1, 8'hA4));
    do_poll(1'b0);
    eng_write(2, mk(70, 1, 1, 8'h80));
    do_poll(1'b0);
    eng_write(3, mk(1522, 1, 1, 8'h00));
    do_poll(1'b0);
    eng_write(0, mk(64, 1, 1, 8'h88));
    do_poll(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule